// File: doc/BRIEF.md
# Event-Addressed Performance Counter Unit

This unit keeps a bank of event counters in a single-port RAM. Each completed transaction comes with a small set of single-bit properties, for example whether the data was private, whether the access was a read, and whether it hit. The unit joins those bits into a counter address, then reads that counter, adds one and writes it back. The properties are chosen so that they exclude one another. Each transaction therefore lands in exactly one counter, and one RAM replaces a separate register for every event type.

A software-writable run bit starts and stops counting. When counting is stopped and the update engine is idle, a host port can read any counter, which is how results are uploaded after a run. A clear command zeroes every counter one address per cycle. The same sweep runs by itself after reset. Counters saturate at all ones by default. A parameter can select wrapping instead.

Top module: `evctr_unit`

## Requirements
- R1: The counter address is the property vector taken as an unsigned number, its top bit as the address MSB. With properties {private, read, hit} on bits [2:0] and each encoded 1 for true, a shared write miss updates counter 0 and a private read hit updates counter 7.
- R2: Each accepted completion (`evt_valid` high while `run_en` is high and no clear is running) adds exactly one to the addressed counter and leaves every other counter unchanged.
- R3: With `SAT_EN`=1, a counter at all ones stays at all ones when it is incremented and never returns to zero.
- R4: A completion presented while `run_en` is low changes no counter.
- R5: A completion arriving while an update is in progress waits in a one-entry holding register and is counted afterwards. Two completions to the same address in consecutive cycles add two.
- R6: An update takes three cycles (read, increment, write). A completion arriving while an update is in progress and the holding register is already full is discarded. Three completions in three consecutive cycles into an idle unit therefore add two.
- R7: When `rd_req` is sampled high while `run_en` is low, no update is in progress and no clear is running, `rd_valid` is high one cycle later with the counter at `rd_addr` on `rd_data`. In any other case `rd_valid` stays low.
- R8: `clr_req` sampled under the same conditions as a host read sets `clr_busy` for exactly 2^`PROP_W` cycles. Afterwards every counter reads zero. Completions arriving during the sweep are not counted.
- R9: Reset starts the same sweep. `clr_busy` is high from reset release for 2^`PROP_W` cycles, and every counter reads zero after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the clearing sweep |
| run_en | input | 1 | Software run bit: 1 counts, 0 stops counting and opens the host port |
| evt_valid | input | 1 | A transaction completed this cycle |
| evt_props | input | PROP_W | Event-property bits that form the counter address |
| rd_req | input | 1 | Host read request |
| rd_addr | input | PROP_W | Counter to read |
| rd_valid | output | 1 | `rd_data` holds the requested counter |
| rd_data | output | CNT_W | Counter value |
| clr_req | input | 1 | Start zeroing all counters |
| clr_busy | output | 1 | Clearing sweep in progress |

## Verification
The bench builds the unit with `PROP_W`=3 and `CNT_W`=4, keeping saturation on. Eight counters make the full first-level-cache property example and a full read-back of every counter cheap. A 4-bit counter reaches its all-ones limit after fifteen events, so saturation can be driven and observed directly. The short clearing sweep lets the bench count `clr_busy` cycles exactly and confirm that completions arriving during the sweep are lost.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
   typedef enum logic [1:0] {
      UPD_IDLE = 2'd0,
      UPD_RD   = 2'd1,
      UPD_INC  = 2'd2,
      UPD_WR   = 2'd3
   } upd_st_t;
endpackage

// File: rtl/evctr_ram.sv
module evctr_ram #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Registered read, old data returned on a write cycle.
   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/evctr_incr.sv
module evctr_incr #(
   parameter int W      = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   generate
      if (SAT_EN) begin : g_sat
         assign nxt = (&cur) ? cur : cur + W'(1);
      end else begin : g_wrap
         assign nxt = cur + W'(1);
      end
   endgenerate
endmodule

// File: rtl/evctr_seq.sv
module evctr_seq
   import evctr_pkg::*;
#(
   parameter int AW     = 8,
   parameter int DW     = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [AW-1:0] props,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] upd_addr,
   output logic          upd_we,
   output logic [DW-1:0] upd_wdata,
   output logic          upd_busy
);
   upd_st_t       st;
   logic [AW-1:0] act_addr;
   logic [AW-1:0] hold_addr;
   logic          hold_v;
   logic [DW-1:0] wbuf;
   logic [DW-1:0] inc_val;

   evctr_incr #(.W(DW), .SAT_EN(SAT_EN)) u_incr (
      .cur (ram_rdata),
      .nxt (inc_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= UPD_IDLE;
         act_addr  <= '0;
         hold_addr <= '0;
         hold_v    <= 1'b0;
         wbuf      <= '0;
      end else begin
         unique case (st)
            UPD_IDLE: begin
               if (hold_v) begin
                  act_addr <= hold_addr;
                  hold_v   <= 1'b0;
                  st       <= UPD_RD;
               end else if (accept) begin
                  act_addr <= props;
                  st       <= UPD_RD;
               end
            end
            UPD_RD: begin
               st <= UPD_INC;
               if (accept && !hold_v) begin
                  hold_addr <= props;
                  hold_v    <= 1'b1;
               end
            end
            UPD_INC: begin
               st   <= UPD_WR;
               wbuf <= inc_val;
               if (accept && !hold_v) begin
                  hold_addr <= props;
                  hold_v    <= 1'b1;
               end
            end
            UPD_WR: begin
               if (hold_v) begin
                  act_addr <= hold_addr;
                  st       <= UPD_RD;
                  if (accept) hold_addr <= props;
                  else        hold_v    <= 1'b0;
               end else if (accept) begin
                  act_addr <= props;
                  st       <= UPD_RD;
               end else begin
                  st <= UPD_IDLE;
               end
            end
            default: st <= UPD_IDLE;
         endcase
      end
   end

   assign upd_addr  = act_addr;
   assign upd_we    = (st == UPD_WR);
   assign upd_wdata = wbuf;
   assign upd_busy  = (st != UPD_IDLE);
endmodule

// File: rtl/evctr_clr.sv
module evctr_clr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         idx <= idx + AW'(1);
         if (&idx) busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end
   end
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit #(
   parameter int PROP_W = 8,
   parameter int CNT_W  = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              evt_valid,
   input  logic [PROP_W-1:0] evt_props,
   input  logic              rd_req,
   input  logic [PROP_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              clr_req,
   output logic              clr_busy
);
   generate
      if (PROP_W < 1 || PROP_W > 20) begin : g_bad_prop
         $error("evctr_unit: PROP_W must be 1..20");
      end
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
         $error("evctr_unit: CNT_W must be 2..64");
      end
   endgenerate

   logic              accept;
   logic              host_ok;
   logic              upd_busy;
   logic              upd_we;
   logic [PROP_W-1:0] upd_addr;
   logic [CNT_W-1:0]  upd_wdata;
   logic [PROP_W-1:0] clr_idx;
   logic              ram_we;
   logic [PROP_W-1:0] ram_addr;
   logic [CNT_W-1:0]  ram_wdata;
   logic [CNT_W-1:0]  ram_rdata;

   assign accept  = evt_valid & run_en & ~clr_busy;
   assign host_ok = ~run_en & ~upd_busy & ~clr_busy;

   evctr_seq #(.AW(PROP_W), .DW(CNT_W), .SAT_EN(SAT_EN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .props     (evt_props),
      .ram_rdata (ram_rdata),
      .upd_addr  (upd_addr),
      .upd_we    (upd_we),
      .upd_wdata (upd_wdata),
      .upd_busy  (upd_busy)
   );

   evctr_clr #(.AW(PROP_W)) u_clr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (clr_req & host_ok),
      .busy  (clr_busy),
      .idx   (clr_idx)
   );

   always_comb begin
      if (clr_busy)      ram_addr = clr_idx;
      else if (upd_busy) ram_addr = upd_addr;
      else               ram_addr = rd_addr;
   end

   assign ram_we    = clr_busy | upd_we;
   assign ram_wdata = clr_busy ? '0 : upd_wdata;

   evctr_ram #(.AW(PROP_W), .DW(CNT_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_req & host_ok;
   end

   assign rd_data = ram_rdata;
endmodule

// File: rtl/evctr_unit_chk.sv
module evctr_unit_chk #(
   parameter int CNT_W  = 32,
   parameter bit SAT_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             rd_req,
   input logic             rd_valid,
   input logic             clr_busy,
   input logic             upd_busy,
   input logic             ram_we,
   input logic [CNT_W-1:0] ram_wdata
);
   // R7: a read result only follows a request made while stopped and idle
   assert_rd_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req && !run_en && !upd_busy && !clr_busy));

   // R8: the sweep only ever writes zero
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy && ram_we) |-> (ram_wdata == '0));

   // R3: a saturating counter update never writes zero
   generate
      if (SAT_EN) begin : g_sat_chk
         assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ram_we && !clr_busy) |-> (ram_wdata != '0));
      end
   endgenerate

   // R4: while stopped and idle, no update starts
   assert_stopped_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !upd_busy) |=> !upd_busy);

   // R8: the sweep and an update never overlap
   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_busy && upd_busy));
endmodule

bind evctr_unit evctr_unit_chk #(.CNT_W(CNT_W), .SAT_EN(SAT_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .clr_busy  (clr_busy),
   .upd_busy  (upd_busy),
   .ram_we    (ram_we),
   .ram_wdata (ram_wdata)
);

// File: tb/evctr_unit_bench.sv
module evctr_unit_bench;
   localparam int PW  = 3;
   localparam int CW  = 4;
   localparam int N   = 1 << PW;
   localparam int MAXV = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          evt_valid = 1'b0;
   logic [PW-1:0] evt_props = '0;
   logic          rd_req = 1'b0;
   logic [PW-1:0] rd_addr = '0;
   logic          rd_valid;
   logic [CW-1:0] rd_data;
   logic          clr_req = 1'b0;
   logic          clr_busy;

   int n_chk = 0;
   int n_bad = 0;
   int exp_cnt [N];
   bit done = 1'b0;

   always #5 clk = ~clk;

   evctr_unit #(.PROP_W(PW), .CNT_W(CW), .SAT_EN(1'b1)) u_evctr_unit (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .evt_valid(evt_valid),
      .evt_props(evt_props), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .clr_req(clr_req),
      .clr_busy(clr_busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic read_ctr(input int a, output bit v, output int d);
      @(negedge clk);
      rd_req  = 1'b1;
      rd_addr = PW'(a);
      @(negedge clk);
      rd_req = 1'b0;
      v = rd_valid;
      d = int'(rd_data);
   endtask

   task automatic pulse_evt(input int a);
      @(negedge clk);
      evt_valid = 1'b1;
      evt_props = PW'(a);
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic verify_all(input string req);
      bit v;
      int d;
      for (int a = 0; a < N; a++) begin
         read_ctr(a, v, d);
         check(v, req, int'(v), 1);
         check(d == exp_cnt[a], req, d, exp_cnt[a]);
      end
   endtask

   // R9: reset sweep length and zeroed counters
   task automatic t_reset;
      int n = 0;
      @(negedge clk);
      rst_n = 1'b1;
      while (clr_busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      check(n == N, "R9 sweep cycles", n, N);
      for (int a = 0; a < N; a++) exp_cnt[a] = 0;
      verify_all("R9 zero after reset");
   endtask

   // R1 / R2: property bits {private, read, hit} address the counters
   task automatic t_address;
      run_en = 1'b1;
      pulse_evt(3'b000); exp_cnt[0]++; idle(3);   // shared write miss
      for (int i = 0; i < 2; i++) begin
         pulse_evt(3'b111); exp_cnt[7]++; idle(3); // private read hit
      end
      for (int i = 0; i < 3; i++) begin
         pulse_evt(3'b100); exp_cnt[4]++; idle(3); // private write miss
      end
      pulse_evt(3'b011); exp_cnt[3]++; idle(4);   // shared read hit
      run_en = 1'b0;
      idle(2);
      verify_all("R1 R2 addressed counts");
   endtask

   // R4: completions while stopped are ignored
   task automatic t_stopped;
      run_en = 1'b0;
      pulse_evt(2); idle(1);
      pulse_evt(7); idle(4);
      verify_all("R4 stopped ignored");
   endtask

   // R5: held completion, same address back to back, then two addresses
   task automatic t_hold;
      run_en = 1'b1;
      @(negedge clk);
      evt_valid = 1'b1; evt_props = 3'd5;
      @(negedge clk);
      evt_props = 3'd5;
      @(negedge clk);
      evt_valid = 1'b0;
      exp_cnt[5] += 2;
      idle(8);
      @(negedge clk);
      evt_valid = 1'b1; evt_props = 3'd1;
      @(negedge clk);
      evt_props = 3'd2;
      @(negedge clk);
      evt_valid = 1'b0;
      exp_cnt[1]++; exp_cnt[2]++;
      idle(8);
      run_en = 1'b0;
      idle(1);
      verify_all("R5 held completion counted");
   endtask

   // R6: third completion in three cycles is discarded
   task automatic t_drop;
      run_en = 1'b1;
      @(negedge clk);
      evt_valid = 1'b1; evt_props = 3'd6;
      idle(3);
      evt_valid = 1'b0;
      exp_cnt[6] += 2;
      idle(8);
      run_en = 1'b0;
      idle(1);
      verify_all("R6 overflow discarded");
   endtask

   // R3: saturation at all ones
   task automatic t_sat;
      run_en = 1'b1;
      for (int i = 0; i < 20; i++) begin
         pulse_evt(3'd6);
         if (exp_cnt[6] < MAXV) exp_cnt[6]++;
         idle(3);
      end
      run_en = 1'b0;
      idle(2);
      verify_all("R3 saturation");
   endtask

   // R7: reads refused while counting
   task automatic t_rd_running;
      bit v;
      int d;
      run_en = 1'b1;
      read_ctr(4, v, d);
      check(!v, "R7 read while running", int'(v), 0);
      run_en = 1'b0;
      idle(1);
      read_ctr(4, v, d);
      check(v && d == exp_cnt[4], "R7 read while stopped", d, exp_cnt[4]);
   endtask

   // R8: clear sweep, length, ignored completions, zero counters
   task automatic t_clear;
      int n = 0;
      bit v;
      int d;
      @(negedge clk);
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      run_en  = 1'b1;
      evt_valid = 1'b1; evt_props = 3'd3;
      read_ctr(0, v, d);
      check(!v, "R8 read during sweep", int'(v), 0);
      evt_valid = 1'b0;
      n = 2;
      while (clr_busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      check(n == N, "R8 sweep cycles", n, N);
      run_en = 1'b0;
      for (int a = 0; a < N; a++) exp_cnt[a] = 0;
      idle(4);
      verify_all("R8 zero after clear");
   endtask

   initial begin
      idle(3);
      t_reset();
      t_address();
      t_stopped();
      t_hold();
      t_drop();
      t_sat();
      t_rd_running();
      t_clear();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule